// File: doc/BRIEF.md
# Reset and Sleep Wake Controller

This block generates the core reset of a small 8-bit microcontroller and records why the most recent reset or wake-up happened. A power-on indication clears the whole block. The core then stays in reset until the external master-clear line has been released and held high for a fixed, parameterised number of clock cycles. Master-clear is an asynchronous, active-low pin. It passes through a two-flop synchronizer before any logic uses it. Every release of the core reset happens on a clock edge.

A watchdog counter runs while the core executes and while it sleeps. The core clears the counter with a strobe. A SLEEP strobe puts the device into its low-power state and restarts the watchdog count. Two events end sleep: a watchdog time-out, or master-clear going low. Either one restarts the core through reset. Two status flags, time-out and power-down, record the cause. The CPU reads them as bits 4 and 3 of its status register. The block also presents the values that the CPU loads while the core reset is high: all ones for the program counter, all ones for the I/O direction register (1 = input, 0 = output), ones in the six implemented timer-mode bits, and ones in the top three bits of the register-select pointer.

Top module: `rstwake_ctrl`

## Requirements
- R1: While `por` is high, and until the power-on delay has ended, `core_rst`=1, `cold_rst`=1, `sleeping`=0, `to_flag`=1 and `pd_flag`=1. The CPU uses `cold_rst`=1 to clear status bits 7..5 to 000.
- R2: After power-on, the core reset falls only after the synchronized master-clear has been high for `POR_DLY_CYC` consecutive cycles. The fall comes `POR_DLY_CYC`+2 rising edges after `mclr_n` rises. Any low sample of the synchronized master-clear restarts the count.
- R3: When `mclr_n` goes low while the core runs, `core_rst` rises on the third rising edge, and both flags keep their values. The reset stays high while `mclr_n` is low. It falls on the third rising edge after `mclr_n` returns high.
- R4: A `sleep_req` pulse while the core runs sets `sleeping`=1, `to_flag`=1 and `pd_flag`=0 on the next edge, and restarts the watchdog count.
- R5: A `wdt_clr` pulse while the core runs restarts the watchdog count and sets `to_flag`=1 and `pd_flag`=1 on the next edge.
- R6: If the core runs for `WDT_PERIOD` cycles with no clear, `core_rst` is high for exactly `WDT_PULSE` cycles, with `to_flag`=0 and `pd_flag`=1.
- R7: During sleep the watchdog keeps counting from the sleep entry. When it times out `WDT_PERIOD` cycles after entry, `sleeping` falls and a `WDT_PULSE`-cycle reset follows, with `to_flag`=0 and `pd_flag`=0.
- R8: When master-clear is asserted during sleep, `sleeping` falls and `core_rst` rises on the third edge, with `to_flag`=1 and `pd_flag`=0.
- R9: `pc_init` and `dir_init` are all ones, `tmode_init` is six ones and `sel_init` is three ones.
- R10: `sleep_req` and `wdt_clr` have no effect while the core reset is high or while the device sleeps.
- R11: If master-clear and a watchdog time-out occur in the same cycle, master-clear wins. If a time-out coincides with a strobe, the time-out wins. If `sleep_req` and `wdt_clr` arrive together, `sleep_req` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por | input | 1 | Power-on indication, active high, synchronous clear of the block |
| mclr_n | input | 1 | External master-clear, active low, asynchronous |
| sleep_req | input | 1 | One-cycle SLEEP instruction strobe |
| wdt_clr | input | 1 | One-cycle watchdog-clear strobe |
| core_rst | output | 1 | Reset to the CPU core, active high |
| cold_rst | output | 1 | High only during the power-on reset |
| sleeping | output | 1 | Device is in the low-power state |
| to_flag | output | 1 | Time-out status flag (status bit 4) |
| pd_flag | output | 1 | Power-down status flag (status bit 3) |
| pc_init | output | PC_W | Reset load value for the program counter |
| dir_init | output | IO_W | Reset load value for the I/O direction register |
| tmode_init | output | 6 | Reset load value for the timer-mode register |
| sel_init | output | 3 | Reset load value for the top bits of the register-select pointer |

## Verification
The assertions assume two things about the inputs. First, `por` is high from time zero until the first clock edges. Second, `sleep_req` and `wdt_clr` are single-cycle pulses that the core would only issue while it runs. The stimulus drives every input at a falling edge and changes `mclr_n` only after the previous master-clear event has settled. No sequence ever relies on a pulse shorter than one clock. The stimulus still places strobes inside reset and inside sleep to show that they are ignored there.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

    // Operating phase of the controller
    typedef enum logic [2:0] {
        PH_COLD  = 3'd0,  // power-on hold and delay
        PH_RUN   = 3'd1,  // core executing
        PH_SLEEP = 3'd2,  // low-power state
        PH_EXT   = 3'd3,  // master-clear hold
        PH_WDT   = 3'd4   // watchdog reset pulse
    } phase_e;

    // Cause flags seen by the CPU in its status register
    typedef struct packed {
        logic to;   // time-out flag
        logic pd;   // power-down flag
    } cause_t;

    localparam cause_t CAUSE_COLD   = '{to: 1'b1, pd: 1'b1};
    localparam cause_t CAUSE_NAP    = '{to: 1'b1, pd: 1'b0};
    localparam int unsigned TMODE_W = 6;
    localparam int unsigned SEL_HI_W = 3;

    // Flags after a watchdog expiry, depending on whether the part slept
    function automatic cause_t wdt_cause(input logic asleep);
        cause_t c;
        c.to = 1'b0;
        c.pd = ~asleep;
        return c;
    endfunction

    // Flags after master-clear: only a wake from sleep changes them
    function automatic cause_t ext_cause(input logic asleep, input cause_t cur);
        return asleep ? CAUSE_NAP : cur;
    endfunction

    function automatic logic is_active(input phase_e ph);
        return (ph == PH_RUN) || (ph == PH_SLEEP);
    endfunction

endpackage

// File: rtl/rstwake_sync.sv
module rstwake_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstwake_wdog.sv
module rstwake_wdog #(
    parameter int unsigned PERIOD = 2250000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic clr,
    output logic tmo
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_en || clr) cnt <= '0;
        else if (cnt == LAST)      cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign tmo = run_en && (cnt == LAST);

    // R6
    wd_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R7
    wd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (cnt == '0));
endmodule

// File: rtl/rstwake_seq.sv
module rstwake_seq
    import rstwake_pkg::*;
#(
    parameter int unsigned POR_DLY = 2250000,
    parameter int unsigned PULSE   = 8
) (
    input  logic   clk,
    input  logic   por,
    input  logic   mclr_ok,
    input  logic   tmo,
    input  logic   sleep_req,
    input  logic   wdt_clr,
    output phase_e ph_o,
    output cause_t cause_o,
    output logic   wd_clr_o,
    output logic   run_en_o
);
    localparam int unsigned TMAX = (POR_DLY > PULSE) ? POR_DLY : PULSE;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] DLY_LAST   = TW'(POR_DLY - 1);
    localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE - 1);

    phase_e        ph, ph_n;
    cause_t        cause, cause_n;
    logic [TW-1:0] tcnt, tcnt_n;
    logic          in_run, in_sleep;

    assign in_run   = (ph == PH_RUN);
    assign in_sleep = (ph == PH_SLEEP);

    always_comb begin
        ph_n    = ph;
        cause_n = cause;
        tcnt_n  = tcnt;
        if (ph == PH_COLD) begin
            if (!mclr_ok)              tcnt_n = '0;
            else if (tcnt == DLY_LAST) begin
                ph_n   = PH_RUN;
                tcnt_n = '0;
            end else                   tcnt_n = tcnt + 1'b1;
        end else if (!mclr_ok) begin
            ph_n   = PH_EXT;
            tcnt_n = '0;
            if (is_active(ph)) cause_n = ext_cause(in_sleep, cause);
        end else begin
            unique case (ph)
                PH_EXT: ph_n = PH_RUN;
                PH_WDT: begin
                    if (tcnt == PULSE_LAST) begin
                        ph_n   = PH_RUN;
                        tcnt_n = '0;
                    end else tcnt_n = tcnt + 1'b1;
                end
                default: begin
                    if (tmo) begin
                        ph_n    = PH_WDT;
                        tcnt_n  = '0;
                        cause_n = wdt_cause(in_sleep);
                    end else if (in_run && sleep_req) begin
                        ph_n    = PH_SLEEP;
                        cause_n = CAUSE_NAP;
                    end else if (in_run && wdt_clr) begin
                        cause_n = CAUSE_COLD;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            ph    <= PH_COLD;
            cause <= CAUSE_COLD;
            tcnt  <= '0;
        end else begin
            ph    <= ph_n;
            cause <= cause_n;
            tcnt  <= tcnt_n;
        end
    end

    assign wd_clr_o = in_run && mclr_ok && !tmo && (sleep_req || wdt_clr);
    assign run_en_o = is_active(ph);
    assign ph_o     = ph;
    assign cause_o  = cause;

    // R1
    cold_flags_chk: assert property (@(posedge clk) disable iff (por)
        (ph == PH_COLD) |-> (cause == CAUSE_COLD));
    // R2
    cold_hold_chk: assert property (@(posedge clk) disable iff (por)
        (ph == PH_COLD && !mclr_ok) |=> (ph == PH_COLD));
    // R3
    ext_run_chk: assert property (@(posedge clk) disable iff (por)
        (in_run && !mclr_ok) |=> (ph == PH_EXT && $stable(cause)));
    // R8
    ext_wake_chk: assert property (@(posedge clk) disable iff (por)
        (in_sleep && !mclr_ok) |=> (ph == PH_EXT && cause.to && !cause.pd));
    // R7
    wdt_wake_chk: assert property (@(posedge clk) disable iff (por)
        (in_sleep && mclr_ok && tmo) |=> (ph == PH_WDT && !cause.to && !cause.pd));
    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (por)
        (ph == PH_WDT) |-> (tcnt <= PULSE_LAST));
    // R10
    strobe_idle_chk: assert property (@(posedge clk) disable iff (por)
        (!in_run && ph != PH_SLEEP && mclr_ok) |=> (ph != PH_SLEEP));
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
    import rstwake_pkg::*;
#(
    parameter int unsigned POR_DLY_CYC = 2250000,
    parameter int unsigned WDT_PERIOD  = 2250000,
    parameter int unsigned WDT_PULSE   = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PC_W        = 8,
    parameter int unsigned IO_W        = 8
) (
    input  logic                clk,
    input  logic                por,
    input  logic                mclr_n,
    input  logic                sleep_req,
    input  logic                wdt_clr,
    output logic                core_rst,
    output logic                cold_rst,
    output logic                sleeping,
    output logic                to_flag,
    output logic                pd_flag,
    output logic [PC_W-1:0]     pc_init,
    output logic [IO_W-1:0]     dir_init,
    output logic [TMODE_W-1:0]  tmode_init,
    output logic [SEL_HI_W-1:0] sel_init
);
    logic   mclr_ok, tmo, wd_clr, run_en;
    phase_e ph;
    cause_t cause;

    rstwake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (por),
        .d   (mclr_n),
        .q   (mclr_ok)
    );

    rstwake_wdog #(.PERIOD(WDT_PERIOD)) u_wdog (
        .clk    (clk),
        .rst    (por),
        .run_en (run_en),
        .clr    (wd_clr),
        .tmo    (tmo)
    );

    rstwake_seq #(.POR_DLY(POR_DLY_CYC), .PULSE(WDT_PULSE)) u_seq (
        .clk       (clk),
        .por       (por),
        .mclr_ok   (mclr_ok),
        .tmo       (tmo),
        .sleep_req (sleep_req),
        .wdt_clr   (wdt_clr),
        .ph_o      (ph),
        .cause_o   (cause),
        .wd_clr_o  (wd_clr),
        .run_en_o  (run_en)
    );

    assign core_rst   = !is_active(ph);
    assign cold_rst   = (ph == PH_COLD);
    assign sleeping   = (ph == PH_SLEEP);
    assign to_flag    = cause.to;
    assign pd_flag    = cause.pd;
    assign pc_init    = '1;
    assign dir_init   = '1;
    assign tmode_init = '1;
    assign sel_init   = '1;

    // R11
    mclr_first_chk: assert property (@(posedge clk) disable iff (por)
        (!core_rst && !mclr_ok && tmo) |=> (core_rst && !cold_rst && $stable(to_flag)));
    // R4
    nap_entry_chk: assert property (@(posedge clk) disable iff (por)
        $rose(sleeping) |-> (to_flag && !pd_flag && !core_rst));
endmodule

// File: tb/sim_rstwake_ctrl.sv
module sim_rstwake_ctrl;
    localparam int unsigned DLY = 20;
    localparam int unsigned PER = 40;
    localparam int unsigned PLS = 4;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic mclr_n = 1'b0;
    logic sleep_req = 1'b0;
    logic wdt_clr = 1'b0;
    logic core_rst, cold_rst, sleeping, to_flag, pd_flag;
    logic [7:0] pc_init, dir_init;
    logic [5:0] tmode_init;
    logic [2:0] sel_init;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    rstwake_ctrl #(
        .POR_DLY_CYC(DLY), .WDT_PERIOD(PER), .WDT_PULSE(PLS),
        .SYNC_STAGES(2), .PC_W(8), .IO_W(8)
    ) u0 (
        .clk(clk), .por(por), .mclr_n(mclr_n), .sleep_req(sleep_req),
        .wdt_clr(wdt_clr), .core_rst(core_rst), .cold_rst(cold_rst),
        .sleeping(sleeping), .to_flag(to_flag), .pd_flag(pd_flag),
        .pc_init(pc_init), .dir_init(dir_init), .tmode_init(tmode_init),
        .sel_init(sel_init)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue one expectation {rst, sleep, to, pd, cold}
    task automatic expect_st(input string tag, input logic r, input logic s,
                             input logic t, input logic p, input logic c);
        exp_q.push_back({r, s, t, p, c});
        tag_q.push_back(tag);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    endtask

    task automatic pulse_clr();
        wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
    endtask

    // Monitor side: pop and compare just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [4:0] e;
                logic [4:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {core_rst, sleeping, to_flag, pd_flag, cold_rst};
                vectors++;
                if (a !== e) begin
                    miscompares++;
                    $display("FAIL %s: rst/slp/to/pd/cold actual %b expected %b", t, a, e);
                end
            end
        end
    end

    task automatic check_vec(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        step(3);
        expect_st("R1 power-on hold", 1, 0, 1, 1, 1);
        // R9 reset load values
        check_vec("R9 pc_init", 32'(pc_init), 32'hFF);
        check_vec("R9 dir_init", 32'(dir_init), 32'hFF);
        check_vec("R9 tmode_init", 32'(tmode_init), 32'h3F);
        check_vec("R9 sel_init", 32'(sel_init), 32'h7);
        por = 1'b0;
        step(5);
        expect_st("R1 held while mclr low", 1, 0, 1, 1, 1);

        // R2 delay restart on a one-cycle low glitch
        mclr_n = 1'b1; step(10);
        mclr_n = 1'b0; step(1);
        mclr_n = 1'b1;
        step(DLY + 1);
        expect_st("R2 still in reset", 1, 0, 1, 1, 1);
        step(1);
        expect_st("R2 released", 0, 0, 1, 1, 0);

        // R6 watchdog expiry while running
        step(PER - 1);
        expect_st("R6 before expiry", 0, 0, 1, 1, 0);
        step(1);
        expect_st("R6 expiry reset", 1, 0, 0, 1, 0);
        step(PLS - 1);
        expect_st("R6 pulse end", 1, 0, 0, 1, 0);
        step(1);
        expect_st("R6 released", 0, 0, 0, 1, 0);

        // R5 watchdog clear restarts count
        step(10);
        pulse_clr();
        expect_st("R5 flags set", 0, 0, 1, 1, 0);
        step(PER - 1);
        expect_st("R5 no early expiry", 0, 0, 1, 1, 0);
        step(1);
        expect_st("R5 expiry after clear", 1, 0, 0, 1, 0);
        step(PLS);

        // R4 sleep entry, R10 clear ignored in sleep, R7 wake by watchdog
        step(3);
        pulse_sleep();
        expect_st("R4 sleeping", 0, 1, 1, 0, 0);
        step(5);
        pulse_clr();
        expect_st("R10 clear ignored in sleep", 0, 1, 1, 0, 0);
        step(PER - 7);
        expect_st("R7 still asleep", 0, 1, 1, 0, 0);
        step(1);
        expect_st("R7 watchdog wake", 1, 0, 0, 0, 0);
        step(PLS);
        expect_st("R7 released", 0, 0, 0, 0, 0);

        // R8 master-clear wake
        step(2);
        pulse_sleep();
        expect_st("R4 sleeping again", 0, 1, 1, 0, 0);
        step(2);
        mclr_n = 1'b0;
        step(2);
        expect_st("R8 sync latency", 0, 1, 1, 0, 0);
        step(1);
        expect_st("R8 master-clear wake", 1, 0, 1, 0, 0);
        pulse_sleep();
        step(3);
        expect_st("R10 sleep ignored in reset", 1, 0, 1, 0, 0);
        mclr_n = 1'b1;
        step(2);
        expect_st("R3 hold until synced", 1, 0, 1, 0, 0);
        step(1);
        expect_st("R3 release", 0, 0, 1, 0, 0);

        // R11 sleep wins over clear in the same cycle
        step(2);
        sleep_req = 1'b1; wdt_clr = 1'b1; step(1);
        sleep_req = 1'b0; wdt_clr = 1'b0;
        expect_st("R11 sleep beats clear", 0, 1, 1, 0, 0);
        step(2);
        mclr_n = 1'b0; step(3);
        expect_st("R8 wake again", 1, 0, 1, 0, 0);
        mclr_n = 1'b1; step(3);
        expect_st("R3 release again", 0, 0, 1, 0, 0);

        // R3 master-clear while running keeps flags
        step(2);
        pulse_clr();
        expect_st("R5 flags set again", 0, 0, 1, 1, 0);
        step(PER);
        expect_st("R6 expiry again", 1, 0, 0, 1, 0);
        step(PLS);
        expect_st("R6 released again", 0, 0, 0, 1, 0);
        step(2);
        mclr_n = 1'b0; step(3);
        expect_st("R3 run reset keeps flags", 1, 0, 0, 1, 0);
        step(4);
        expect_st("R3 held while low", 1, 0, 0, 1, 0);
        mclr_n = 1'b1; step(3);
        expect_st("R3 released keeps flags", 0, 0, 0, 1, 0);

        // R1 power-on again mid-run
        step(2);
        por = 1'b1; step(1);
        expect_st("R1 power-on restores", 1, 0, 1, 1, 1);
        por = 1'b0;
        step(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule